// File: doc/BRIEF.md
# DMA Channel Descriptor Preemption Engine

This block holds the working transfer descriptors for a small multi-channel DMA engine and produces the source and destination address of every read/write pair. Two descriptor register sets exist. Set X serves a channel that was started from idle. Set Y serves a channel that preempts the one in set X. A channel executes its minor loop one pair at a time, and a pulse on `acc_done` marks the end of each pair. At each pair end the block moves both addresses by their signed per-descriptor offsets. When the minor loop ends, the block writes the descriptor back to the local descriptor memory. At the end of the major loop it applies the signed final adjustments, reloads the iteration count and can chain to a linked descriptor.

Arbitration uses a fixed priority in which a higher channel number wins. A channel that runs in X and has its preemption enable bit set gives way to a higher requesting channel. This can only happen at a pair boundary. When the preempting channel finishes its minor loop, the X channel resumes from the values it holds in its registers, and no descriptor is read again. Preemption goes at most one level deep. The descriptor memory, the data movement and the bus protocol lie outside the block. Requests are levels, and each started activation runs one minor loop. The requester drops its request once it sees its channel running.

Top module: `dma_desc_preempt`

## Requirements
- R1: After reset, `acc_vld`, `rd_req` and `wb_req` are low.
- R2: When idle, the block raises `rd_req` for exactly one cycle, with `rd_idx` equal to the highest-numbered requesting channel. It then waits for `rd_vld`, loads the returned record into set X, and drives `acc_vld` high with `acc_pre` low, `acc_ch` equal to that channel and `acc_src`/`acc_dst` equal to the loaded addresses.
- R3: On each `acc_done`, `acc_src` and `acc_dst` advance by the sign-extended `soff` and `doff`. The new values are visible in the next cycle.
- R4: After `nmin` `acc_done` pulses, `acc_vld` falls and `wb_req` pulses for one cycle. The pulse carries `wb_idx` equal to the channel number, the advanced addresses and `citer` reduced by one. All other fields keep their loaded values.
- R5: When a minor loop ends with `citer` equal to 1, the write-back adds `slast`/`dlast` to the advanced addresses and sets `citer` back to `biter`. With `link` clear, nothing further is read.
- R6: When R5 applies and `link` is set, the block follows the write-back with a read of record `next`. It then writes that record unchanged into the channel's slot, with `wb_idx` equal to the channel number.
- R7: A channel running in X with its `pre_en` bit set is preempted by a higher-numbered request at a non-final `acc_done`. In the cycle after that pulse, `acc_vld` is low and `rd_req` is high for the higher channel. That channel then runs with `acc_pre` high.
- R8: A channel running in X whose `pre_en` bit is clear completes its minor loop. A higher request waiting during that loop starts afterwards as a normal start with `acc_pre` low.
- R9: Once `acc_vld` is high, it stays high and the addresses stay unchanged until `acc_done` arrives, whatever the requests do.
- R10: In the cycle after the preempting channel's write-back, the X channel runs again with `acc_pre` low. It continues from its saved addresses and remaining pair count, and no descriptor read takes place.
- R11: A channel running in Y is never preempted. It keeps `acc_vld` and `acc_pre` high across `acc_done` pulses until its minor loop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Channel activation requests (level) |
| pre_en | input | NCH | Per-channel preemption enable |
| rd_req | output | 1 | Descriptor read request, one cycle |
| rd_idx | output | IW | Record index to read |
| rd_vld | input | 1 | Read record valid |
| rd_saddr | input | AW | Read record source address |
| rd_daddr | input | AW | Read record destination address |
| rd_soff | input | OW | Read record signed source offset |
| rd_doff | input | OW | Read record signed destination offset |
| rd_slast | input | AW | Read record signed final source adjustment |
| rd_dlast | input | AW | Read record signed final destination adjustment |
| rd_nmin | input | MW | Read record pairs per minor loop |
| rd_citer | input | CW | Read record current iteration count |
| rd_biter | input | CW | Read record starting iteration count |
| rd_link | input | 1 | Read record chaining enable |
| rd_next | input | IW | Read record index of linked record |
| acc_vld | output | 1 | A read/write pair is being executed |
| acc_ch | output | CHW | Channel of the current pair |
| acc_pre | output | 1 | Current pair comes from set Y |
| acc_src | output | AW | Source address of current pair |
| acc_dst | output | AW | Destination address of current pair |
| acc_done | input | 1 | Current pair finished |
| wb_req | output | 1 | Descriptor write request, one cycle |
| wb_idx | output | IW | Record index to write |
| wb_saddr | output | AW | Written source address |
| wb_daddr | output | AW | Written destination address |
| wb_soff | output | OW | Written source offset |
| wb_doff | output | OW | Written destination offset |
| wb_slast | output | AW | Written final source adjustment |
| wb_dlast | output | AW | Written final destination adjustment |
| wb_nmin | output | MW | Written pairs per minor loop |
| wb_citer | output | CW | Written current iteration count |
| wb_biter | output | CW | Written starting iteration count |
| wb_link | output | 1 | Written chaining enable |
| wb_next | output | IW | Written linked record index |

## Verification
The embedded properties watch the pair boundary on every cycle: `acc_vld` cannot fall before `acc_done`, a preemption read only starts when the X channel allows it, a Y channel survives every non-final pair, and the release of Y always resumes X. They also check that a write-back lasts one cycle, that it never overlaps an access, and that a major-loop write-back carries the reloaded count. The correctness of the address arithmetic, the choice of the winning channel, the contents of a chained record and the exact resume values can only be shown by the directed scenarios. Those scenarios compare against expected values computed independently.

// File: rtl/dma_desc_preempt.sv
`timescale 1ns/1ps
module dma_desc_preempt #(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int MW   = 8,
  parameter int CW   = 12,
  parameter int RECS = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW  = (RECS > 1) ? $clog2(RECS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] pre_en,
  output logic           rd_req,
  output logic [IW-1:0]  rd_idx,
  input  logic           rd_vld,
  input  logic [AW-1:0]  rd_saddr,
  input  logic [AW-1:0]  rd_daddr,
  input  logic [OW-1:0]  rd_soff,
  input  logic [OW-1:0]  rd_doff,
  input  logic [AW-1:0]  rd_slast,
  input  logic [AW-1:0]  rd_dlast,
  input  logic [MW-1:0]  rd_nmin,
  input  logic [CW-1:0]  rd_citer,
  input  logic [CW-1:0]  rd_biter,
  input  logic           rd_link,
  input  logic [IW-1:0]  rd_next,
  output logic           acc_vld,
  output logic [CHW-1:0] acc_ch,
  output logic           acc_pre,
  output logic [AW-1:0]  acc_src,
  output logic [AW-1:0]  acc_dst,
  input  logic           acc_done,
  output logic           wb_req,
  output logic [IW-1:0]  wb_idx,
  output logic [AW-1:0]  wb_saddr,
  output logic [AW-1:0]  wb_daddr,
  output logic [OW-1:0]  wb_soff,
  output logic [OW-1:0]  wb_doff,
  output logic [AW-1:0]  wb_slast,
  output logic [AW-1:0]  wb_dlast,
  output logic [MW-1:0]  wb_nmin,
  output logic [CW-1:0]  wb_citer,
  output logic [CW-1:0]  wb_biter,
  output logic           wb_link,
  output logic [IW-1:0]  wb_next
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RW, S_RUN, S_WB} st_t;

  st_t st;
  logic cur, tgt, lnk, mend;
  logic [IW-1:0] rdi;

  logic [AW-1:0]  s_sa [2];
  logic [AW-1:0]  s_da [2];
  logic [OW-1:0]  s_so [2];
  logic [OW-1:0]  s_do [2];
  logic [AW-1:0]  s_sl [2];
  logic [AW-1:0]  s_dl [2];
  logic [MW-1:0]  s_nm [2];
  logic [MW-1:0]  s_rem[2];
  logic [CW-1:0]  s_ci [2];
  logic [CW-1:0]  s_bi [2];
  logic           s_lk [2];
  logic [IW-1:0]  s_nx [2];
  logic [CHW-1:0] s_ch [2];
  logic [1:0]     vset;

  logic [NCH-1:0] held, elig;
  logic [CHW-1:0] top;
  logic           any;

  function automatic logic [AW-1:0] sx(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  always_comb begin
    held = '0;
    for (int i = 0; i < NCH; i++) begin
      if (vset[0] && s_ch[0] == CHW'(i)) held[i] = 1'b1;
      if (vset[1] && s_ch[1] == CHW'(i)) held[i] = 1'b1;
    end
    elig = req & ~held;
    top  = '0;
    any  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i]) begin
        top = CHW'(i);
        any = 1'b1;
      end
    end
  end

  logic last_pair, major_end, pre_ok;
  assign last_pair = s_rem[cur] <= MW'(1);
  assign major_end = s_ci[cur] <= CW'(1);
  assign pre_ok    = !cur && !vset[1] && pre_en[s_ch[0]] && any && (top > s_ch[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= 1'b0;
      tgt  <= 1'b0;
      lnk  <= 1'b0;
      mend <= 1'b0;
      rdi  <= '0;
      vset <= '0;
      for (int k = 0; k < 2; k++) begin
        s_sa[k] <= '0; s_da[k] <= '0; s_so[k] <= '0; s_do[k] <= '0;
        s_sl[k] <= '0; s_dl[k] <= '0; s_nm[k] <= '0; s_rem[k] <= '0;
        s_ci[k] <= '0; s_bi[k] <= '0; s_lk[k] <= 1'b0; s_nx[k] <= '0;
        s_ch[k] <= '0;
      end
    end else begin
      unique case (st)
        S_IDLE: if (any) begin
          tgt     <= 1'b0;
          s_ch[0] <= top;
          rdi     <= IW'(top);
          st      <= S_RD;
        end
        S_RD: st <= S_RW;
        S_RW: if (rd_vld) begin
          if (lnk) begin
            s_sa[cur] <= rd_saddr; s_da[cur] <= rd_daddr;
            s_so[cur] <= rd_soff;  s_do[cur] <= rd_doff;
            s_sl[cur] <= rd_slast; s_dl[cur] <= rd_dlast;
            s_nm[cur] <= rd_nmin;  s_ci[cur] <= rd_citer;
            s_bi[cur] <= rd_biter; s_lk[cur] <= rd_link;
            s_nx[cur] <= rd_next;
            st        <= S_WB;
          end else begin
            s_sa[tgt]  <= rd_saddr; s_da[tgt] <= rd_daddr;
            s_so[tgt]  <= rd_soff;  s_do[tgt] <= rd_doff;
            s_sl[tgt]  <= rd_slast; s_dl[tgt] <= rd_dlast;
            s_nm[tgt]  <= rd_nmin;  s_ci[tgt] <= rd_citer;
            s_bi[tgt]  <= rd_biter; s_lk[tgt] <= rd_link;
            s_nx[tgt]  <= rd_next;
            s_rem[tgt] <= rd_nmin;
            vset[tgt]  <= 1'b1;
            cur        <= tgt;
            st         <= S_RUN;
          end
        end
        S_RUN: if (acc_done) begin
          s_rem[cur] <= s_rem[cur] - MW'(1);
          if (last_pair) begin
            if (major_end) begin
              s_sa[cur] <= s_sa[cur] + sx(s_so[cur]) + s_sl[cur];
              s_da[cur] <= s_da[cur] + sx(s_do[cur]) + s_dl[cur];
              s_ci[cur] <= s_bi[cur];
              mend      <= 1'b1;
            end else begin
              s_sa[cur] <= s_sa[cur] + sx(s_so[cur]);
              s_da[cur] <= s_da[cur] + sx(s_do[cur]);
              s_ci[cur] <= s_ci[cur] - CW'(1);
            end
            st <= S_WB;
          end else begin
            s_sa[cur] <= s_sa[cur] + sx(s_so[cur]);
            s_da[cur] <= s_da[cur] + sx(s_do[cur]);
            if (pre_ok) begin
              tgt     <= 1'b1;
              s_ch[1] <= top;
              rdi     <= IW'(top);
              st      <= S_RD;
            end
          end
        end
        S_WB: begin
          if (mend && s_lk[cur] && !lnk) begin
            lnk <= 1'b1;
            rdi <= s_nx[cur];
            st  <= S_RD;
          end else begin
            lnk       <= 1'b0;
            mend      <= 1'b0;
            vset[cur] <= 1'b0;
            if (cur) begin
              cur <= 1'b0;
              st  <= S_RUN;
            end else begin
              st  <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req   = st == S_RD;
  assign rd_idx   = rdi;
  assign acc_vld  = st == S_RUN;
  assign acc_ch   = s_ch[cur];
  assign acc_pre  = cur;
  assign acc_src  = s_sa[cur];
  assign acc_dst  = s_da[cur];
  assign wb_req   = st == S_WB;
  assign wb_idx   = IW'(s_ch[cur]);
  assign wb_saddr = s_sa[cur];
  assign wb_daddr = s_da[cur];
  assign wb_soff  = s_so[cur];
  assign wb_doff  = s_do[cur];
  assign wb_slast = s_sl[cur];
  assign wb_dlast = s_dl[cur];
  assign wb_nmin  = s_nm[cur];
  assign wb_citer = s_ci[cur];
  assign wb_biter = s_bi[cur];
  assign wb_link  = s_lk[cur];
  assign wb_next  = s_nx[cur];

  a_r9_pair_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !acc_done |=> acc_vld);

  a_r7_pre_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && tgt && !lnk) |-> (vset[0] && pre_en[s_ch[0]] && s_ch[1] > s_ch[0]));

  a_r11_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_pre && acc_done && s_rem[1] > MW'(1)) |=> (acc_vld && acc_pre));

  a_r4_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && mend && !lnk) |-> (wb_citer == wb_biter));

  a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && acc_pre && !(mend && s_lk[1] && !lnk)) |=> (acc_vld && !acc_pre && !rd_req));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && (rd_req || wb_req)));

endmodule

// File: tb/dma_desc_preempt_bench.sv
`timescale 1ns/1ps
module dma_desc_preempt_bench;
  localparam int NCH = 4, AW = 32, OW = 16, MW = 8, CW = 12, RECS = 8;
  localparam int CHW = 2, IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0, pre_en = '0;
  logic acc_done = 1'b0;
  logic rd_req, acc_vld, acc_pre, wb_req;
  logic [IW-1:0] rd_idx, wb_idx, wb_next;
  logic [CHW-1:0] acc_ch;
  logic [AW-1:0] acc_src, acc_dst;
  logic [AW-1:0] wb_saddr, wb_daddr, wb_slast, wb_dlast;
  logic [OW-1:0] wb_soff, wb_doff;
  logic [MW-1:0] wb_nmin;
  logic [CW-1:0] wb_citer, wb_biter;
  logic wb_link;

  logic rd_vld = 1'b0;
  logic [AW-1:0] r_sa = '0, r_da = '0, r_sl = '0, r_dl = '0;
  logic [OW-1:0] r_so = '0, r_do = '0;
  logic [MW-1:0] r_nm = '0;
  logic [CW-1:0] r_ci = '0, r_bi = '0;
  logic r_lk = 1'b0;
  logic [IW-1:0] r_nx = '0;

  logic [AW-1:0] m_sa[RECS], m_da[RECS], m_sl[RECS], m_dl[RECS];
  logic [OW-1:0] m_so[RECS], m_do[RECS];
  logic [MW-1:0] m_nm[RECS];
  logic [CW-1:0] m_ci[RECS], m_bi[RECS];
  logic m_lk[RECS];
  logic [IW-1:0] m_nx[RECS];

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dma_desc_preempt u_dma_desc_preempt (
    .clk(clk), .rst_n(rst_n), .req(req), .pre_en(pre_en),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_vld(rd_vld),
    .rd_saddr(r_sa), .rd_daddr(r_da), .rd_soff(r_so), .rd_doff(r_do),
    .rd_slast(r_sl), .rd_dlast(r_dl), .rd_nmin(r_nm), .rd_citer(r_ci),
    .rd_biter(r_bi), .rd_link(r_lk), .rd_next(r_nx),
    .acc_vld(acc_vld), .acc_ch(acc_ch), .acc_pre(acc_pre),
    .acc_src(acc_src), .acc_dst(acc_dst), .acc_done(acc_done),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_saddr(wb_saddr), .wb_daddr(wb_daddr),
    .wb_soff(wb_soff), .wb_doff(wb_doff), .wb_slast(wb_slast), .wb_dlast(wb_dlast),
    .wb_nmin(wb_nmin), .wb_citer(wb_citer), .wb_biter(wb_biter),
    .wb_link(wb_link), .wb_next(wb_next)
  );

  always @(posedge clk) begin
    rd_vld <= rd_req;
    if (rd_req) begin
      r_sa <= m_sa[rd_idx]; r_da <= m_da[rd_idx]; r_so <= m_so[rd_idx];
      r_do <= m_do[rd_idx]; r_sl <= m_sl[rd_idx]; r_dl <= m_dl[rd_idx];
      r_nm <= m_nm[rd_idx]; r_ci <= m_ci[rd_idx]; r_bi <= m_bi[rd_idx];
      r_lk <= m_lk[rd_idx]; r_nx <= m_nx[rd_idx];
    end
    if (wb_req) begin
      m_sa[wb_idx] <= wb_saddr; m_da[wb_idx] <= wb_daddr; m_so[wb_idx] <= wb_soff;
      m_do[wb_idx] <= wb_doff; m_sl[wb_idx] <= wb_slast; m_dl[wb_idx] <= wb_dlast;
      m_nm[wb_idx] <= wb_nmin; m_ci[wb_idx] <= wb_citer; m_bi[wb_idx] <= wb_biter;
      m_lk[wb_idx] <= wb_link; m_nx[wb_idx] <= wb_next;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_desc(input int i, input logic [31:0] sa, input logic [31:0] da,
                          input logic [15:0] so, input logic [15:0] dof,
                          input logic [31:0] sl, input logic [31:0] dl,
                          input int nm, input int ci, input int bi,
                          input logic lk, input int nx);
    m_sa[i] <= sa; m_da[i] <= da; m_so[i] <= so; m_do[i] <= dof;
    m_sl[i] <= sl; m_dl[i] <= dl; m_nm[i] <= MW'(nm); m_ci[i] <= CW'(ci);
    m_bi[i] <= CW'(bi); m_lk[i] <= lk; m_nx[i] <= IW'(nx);
  endtask

  task automatic pair();
    @(negedge clk) acc_done = 1'b1;
    @(negedge clk) acc_done = 1'b0;
  endtask

  task automatic wait_acc(input string tag);
    int n = 0;
    while (!acc_vld && n < 50) begin @(negedge clk); n++; end
    if (!acc_vld) chk({tag, " acc_vld timeout"}, 32'd0, 32'd1);
  endtask

  task automatic wait_rd(input string tag);
    int n = 0;
    while (!rd_req && n < 50) begin @(negedge clk); n++; end
    if (!rd_req) chk({tag, " rd_req timeout"}, 32'd0, 32'd1);
  endtask

  task automatic wait_wb(input string tag);
    int n = 0;
    while (!wb_req && n < 50) begin @(negedge clk); n++; end
    if (!wb_req) chk({tag, " wb_req timeout"}, 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 acc_vld", 32'(acc_vld), 32'd0);
    chk("R1 rd_req", 32'(rd_req), 32'd0);
    chk("R1 wb_req", 32'(wb_req), 32'd0);
  endtask

  task automatic t_basic();
    set_desc(1, 32'h1000, 32'h2000, 16'd4, 16'hFFFC, 0, 0, 3, 5, 5, 1'b0, 0);
    set_desc(0, 32'h100, 32'h300, 16'd8, 16'd2, 32'hFFFFFFF0, 32'h20, 1, 1, 2, 1'b0, 0);
    @(negedge clk) req = 4'b0011;
    wait_rd("R2");
    chk("R2 rd_idx priority", 32'(rd_idx), 32'd1);
    wait_acc("R2");
    req[1] = 1'b0;
    chk("R2 acc_ch", 32'(acc_ch), 32'd1);
    chk("R2 acc_pre", 32'(acc_pre), 32'd0);
    chk("R2 src", acc_src, 32'h1000);
    chk("R2 dst", acc_dst, 32'h2000);
    pair();
    chk("R3 src +4", acc_src, 32'h1004);
    chk("R3 dst -4", acc_dst, 32'h1FFC);
    pair();
    pair();
    wait_wb("R4");
    chk("R4 acc_vld low", 32'(acc_vld), 32'd0);
    chk("R4 wb_idx", 32'(wb_idx), 32'd1);
    chk("R4 wb_saddr", wb_saddr, 32'h100C);
    chk("R4 wb_daddr", wb_daddr, 32'h1FF4);
    chk("R4 wb_citer", 32'(wb_citer), 32'd4);
    chk("R4 wb_soff kept", 32'(wb_soff), 32'd4);
    chk("R4 wb_biter kept", 32'(wb_biter), 32'd5);
    @(negedge clk);
    chk("R4 wb single", 32'(wb_req), 32'd0);
    wait_acc("R2 second");
    req[0] = 1'b0;
    chk("R2 lower channel next", 32'(acc_ch), 32'd0);
    pair();
    wait_wb("R5");
    chk("R5 wb_saddr last adj", wb_saddr, 32'hF8);
    chk("R5 wb_daddr last adj", wb_daddr, 32'h322);
    chk("R5 citer reload", 32'(wb_citer), 32'd2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 no read without link", 32'(rd_req), 32'd0);
    end
  endtask

  task automatic t_link();
    set_desc(2, 32'h4000, 32'h5000, 16'd1, 16'd1, 0, 0, 2, 1, 7, 1'b1, 6);
    set_desc(6, 32'hAAAA0000, 32'hBBBB0000, 16'd2, 16'd2, 0, 0, 5, 9, 9, 1'b0, 0);
    @(negedge clk) req = 4'b0100;
    wait_acc("R6");
    req = '0;
    pair();
    pair();
    wait_wb("R6 first");
    chk("R6 first wb saddr", wb_saddr, 32'h4002);
    chk("R6 first wb citer", 32'(wb_citer), 32'd7);
    @(negedge clk);
    wait_rd("R6");
    chk("R6 rd_idx link", 32'(rd_idx), 32'd6);
    wait_wb("R6 second");
    chk("R6 link wb_idx", 32'(wb_idx), 32'd2);
    chk("R6 link saddr", wb_saddr, 32'hAAAA0000);
    chk("R6 link nmin", 32'(wb_nmin), 32'd5);
    chk("R6 link citer", 32'(wb_citer), 32'd9);
    repeat (2) @(negedge clk);
    chk("R6 slot holds linked dst", m_da[2], 32'hBBBB0000);
    chk("R6 idle after link", 32'(acc_vld), 32'd0);
  endtask

  task automatic t_preempt();
    set_desc(1, 32'h100, 32'h800, 16'd4, 16'd4, 0, 0, 4, 3, 3, 1'b0, 0);
    set_desc(3, 32'h9000, 32'h9100, 16'hFFFE, 16'd0, 0, 0, 2, 2, 2, 1'b0, 0);
    pre_en = 4'b1111;
    @(negedge clk) req = 4'b0010;
    wait_acc("R7");
    req = '0;
    pair();
    req[3] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no preempt mid pair vld", 32'(acc_vld), 32'd1);
      chk("R9 no preempt mid pair ch", 32'(acc_ch), 32'd1);
      chk("R9 src held", acc_src, 32'h104);
    end
    pair();
    chk("R7 acc_vld drops", 32'(acc_vld), 32'd0);
    chk("R7 rd_req", 32'(rd_req), 32'd1);
    chk("R7 rd_idx", 32'(rd_idx), 32'd3);
    wait_acc("R7 run");
    req[3] = 1'b0;
    chk("R7 acc_ch", 32'(acc_ch), 32'd3);
    chk("R7 acc_pre", 32'(acc_pre), 32'd1);
    chk("R7 src", acc_src, 32'h9000);
    pair();
    chk("R3 negative offset", acc_src, 32'h8FFE);
    pair();
    wait_wb("R7 wb");
    chk("R7 wb_idx", 32'(wb_idx), 32'd3);
    chk("R7 wb saddr", wb_saddr, 32'h8FFC);
    @(negedge clk);
    chk("R10 resumed vld", 32'(acc_vld), 32'd1);
    chk("R10 resumed ch", 32'(acc_ch), 32'd1);
    chk("R10 resumed pre", 32'(acc_pre), 32'd0);
    chk("R10 resumed src", acc_src, 32'h108);
    chk("R10 resumed dst", acc_dst, 32'h808);
    chk("R10 no reload", 32'(rd_req), 32'd0);
    pair();
    pair();
    wait_wb("R10 wb");
    chk("R10 wb_idx", 32'(wb_idx), 32'd1);
    chk("R10 wb saddr", wb_saddr, 32'h110);
    chk("R10 wb citer", 32'(wb_citer), 32'd2);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_one_level();
    set_desc(0, 32'h0, 32'h40, 16'd1, 16'd1, 0, 0, 3, 4, 4, 1'b0, 0);
    set_desc(2, 32'h600, 32'h700, 16'd1, 16'd1, 0, 0, 3, 4, 4, 1'b0, 0);
    pre_en = 4'b1111;
    @(negedge clk) req = 4'b0001;
    wait_acc("R11");
    req = '0;
    pair();
    req[2] = 1'b1;
    pair();
    wait_acc("R11 pre");
    req[2] = 1'b0;
    chk("R11 Y channel", 32'(acc_ch), 32'd2);
    req[3] = 1'b1;
    pair();
    chk("R11 Y not preempted vld", 32'(acc_vld), 32'd1);
    chk("R11 Y not preempted ch", 32'(acc_ch), 32'd2);
    chk("R11 Y not preempted pre", 32'(acc_pre), 32'd1);
    pair();
    chk("R11 Y still running", 32'(acc_ch), 32'd2);
    req[3] = 1'b0;
    pair();
    wait_wb("R11 wb");
    chk("R11 wb_idx", 32'(wb_idx), 32'd2);
    @(negedge clk);
    chk("R10 X resumes after Y", 32'(acc_ch), 32'd0);
    pair();
    wait_wb("R11 X wb");
    chk("R11 X wb saddr", wb_saddr, 32'h3);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_no_enable();
    set_desc(1, 32'h20, 32'h30, 16'd1, 16'd1, 0, 0, 3, 2, 2, 1'b0, 0);
    set_desc(3, 32'h50, 32'h60, 16'd1, 16'd1, 0, 0, 1, 2, 2, 1'b0, 0);
    pre_en = 4'b0000;
    @(negedge clk) req = 4'b0010;
    wait_acc("R8");
    req = '0;
    req[3] = 1'b1;
    pair();
    chk("R8 no preempt vld", 32'(acc_vld), 32'd1);
    chk("R8 no preempt ch", 32'(acc_ch), 32'd1);
    pair();
    chk("R8 still ch1", 32'(acc_ch), 32'd1);
    pair();
    wait_wb("R8 wb");
    chk("R8 wb_idx", 32'(wb_idx), 32'd1);
    wait_acc("R8 next");
    req[3] = 1'b0;
    chk("R8 waiting channel starts", 32'(acc_ch), 32'd3);
    chk("R8 normal start", 32'(acc_pre), 32'd0);
    pair();
    wait_wb("R8 ch3 wb");
    chk("R8 ch3 wb_idx", 32'(wb_idx), 32'd3);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < RECS; i++) set_desc(i, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1'b0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_link();
    t_preempt();
    t_one_level();
    t_no_enable();
    finish_run();
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule